// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers service requests from eight device lines, from a fault input, from a software trap input and from an internal privilege-violation source. Every source owns a fixed vector number. The controller presents the lowest-numbered eligible vector to the processor. The processor uses that number as an index into its own table of service-routine addresses. When the processor acknowledges, the controller does four things: it takes the presented vector as the new in-service level, forces the privilege mode bit to supervisor, clears the pending bit of that source, and saves the earlier level and mode on an internal context stack.

A return pops the stack and restores the earlier level and mode. While a device handler runs, device lines of equal or lower priority stay pending and are not lost. A strictly higher device line, or any trap, can nest on top of the running handler. The mode bit may be rewritten directly only in supervisor mode. A write attempted in user mode does not change the mode bit and instead raises its own vectored trap.

Top module: `irqc_top`

## Requirements
- R1: After reset, irq_o is 0, mode_o is 0 (supervisor), the context stack is empty and no source is pending.
- R2: The vector numbers are fixed: fault = 0, privilege violation = 1, software trap = 2, device line i = 3+i. When several eligible sources are pending, the lowest vector number is presented on vector_o with irq_o = 1.
- R3: A device pending bit is set in every cycle in which its req_i bit is 1. After req_i falls, the bit stays set until that vector is acknowledged; the acknowledge clears it.
- R4: A pending request that is held off by masking is not dropped. It is presented once a return lowers the in-service level far enough.
- R5: A device vector v is eligible only when v is strictly smaller than the in-service level. The idle level is 11, above every vector.
- R6: A device vector numerically smaller than the running handler's vector preempts it. The acknowledge nests one more context on the stack.
- R7: Fault, privilege-violation and software-trap vectors are eligible at every in-service level.
- R8: An acknowledge taken while irq_o = 1 makes mode_o 0 from the next cycle.
- R9: A return pops the stack and restores the saved level and mode_o. A return with an empty stack has no effect.
- R10: A mode write in supervisor mode sets mode_o to mode_wdata_i in the next cycle. A mode write in user mode leaves mode_o at 1 and raises the privilege-violation vector 1.
- R11: While the stack holds STACK_DEPTH contexts, irq_o is 0. Requests remain pending until a return frees an entry.
- R12: ack_i while irq_o = 0 has no effect. When ack_i and ret_i arrive together, the acknowledge wins and the return is ignored. Either of them overrides a mode write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_LINES | Level-sensitive device requests; bit i maps to vector 3+i |
| trap_i | input | 1 | Software trap instruction pulse (vector 2) |
| fault_i | input | 1 | Execution fault pulse, such as divide by zero (vector 0) |
| ack_i | input | 1 | Processor accepts the presented vector |
| ret_i | input | 1 | Return from the current handler |
| mode_wr_i | input | 1 | Request to write the mode bit |
| mode_wdata_i | input | 1 | New mode value: 0 supervisor, 1 user |
| irq_o | output | 1 | A vector is being presented |
| vector_o | output | VEC_W | Presented vector number |
| mode_o | output | 1 | Privilege mode: 0 supervisor, 1 user |

## Verification
The checker assumes that every control input is a known value at each rising edge after reset. It also assumes that an acknowledge refers to the vector visible in that same cycle. It does not assume that ack_i, ret_i and mode_wr_i are mutually exclusive, because the block gives them a defined order of precedence. The stimulus changes inputs only on falling edges. In its random phase it freely mixes simultaneous acknowledge, return, mode write, trap and device requests. A behavioural model that applies the same precedence rules tracks every one of those combinations.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned TRAP_SRCS  = 3;
  localparam int unsigned VEC_FAULT  = 0;
  localparam int unsigned VEC_PRIV   = 1;
  localparam int unsigned VEC_SWTRAP = 2;
  localparam logic        MODE_SUP   = 1'b0;
  localparam logic        MODE_USR   = 1'b1;
endpackage

// File: rtl/irqc_pend.sv
module irqc_pend #(
  parameter int unsigned NUM_SRC = 11,
  localparam int unsigned VEC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               clr_en_i,
  input  logic [VEC_W-1:0]   clr_idx_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] clr_mask;

  for (genvar v = 0; v < NUM_SRC; v++) begin : g_clr
    assign clr_mask[v] = clr_en_i && (clr_idx_i == VEC_W'(v));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= (pend_o & ~clr_mask) | set_i;
  end
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
  parameter int unsigned NUM_SRC  = 11,
  parameter int unsigned NUM_TRAP = 3,
  localparam int unsigned VEC_W   = $clog2(NUM_SRC),
  localparam int unsigned LVL_W   = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [LVL_W-1:0]   level_i,
  output logic               found_o,
  output logic [VEC_W-1:0]   vec_o
);
  logic [NUM_SRC-1:0] elig;

  for (genvar v = 0; v < NUM_SRC; v++) begin : g_elig
    if (v < NUM_TRAP) begin : g_trap
      assign elig[v] = pend_i[v];
    end else begin : g_dev
      assign elig[v] = pend_i[v] && (LVL_W'(v) < level_i);
    end
  end

  // lowest index wins
  always_comb begin
    found_o = 1'b0;
    vec_o   = '0;
    for (int v = NUM_SRC - 1; v >= 0; v--) begin
      if (elig[v]) begin
        found_o = 1'b1;
        vec_o   = VEC_W'(v);
      end
    end
  end
endmodule

// File: rtl/irqc_stack.sv
module irqc_stack #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 5,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [W-1:0]     din_i,
  output logic [W-1:0]     top_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] depth_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] wr_ptr, top_ptr;

  assign wr_ptr  = PTR_W'(cnt_q);
  assign top_ptr = PTR_W'(cnt_q - CNT_W'(1));
  assign top_o   = mem_q[top_ptr];
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign depth_o = cnt_q;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        mem_q[e] <= '0;
      else if (push_i && !full_o && wr_ptr == PTR_W'(e)) mem_q[e] <= din_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (push_i && !full_o)   cnt_q <= cnt_q + CNT_W'(1);
    else if (pop_i && !empty_o)   cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 8,
  parameter int unsigned STACK_DEPTH = 8,
  localparam int unsigned NUM_SRC    = TRAP_SRCS + NUM_LINES,
  localparam int unsigned VEC_W      = $clog2(NUM_SRC),
  localparam int unsigned LVL_W      = $clog2(NUM_SRC + 1),
  localparam int unsigned CNT_W      = $clog2(STACK_DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic                 trap_i,
  input  logic                 fault_i,
  input  logic                 ack_i,
  input  logic                 ret_i,
  input  logic                 mode_wr_i,
  input  logic                 mode_wdata_i,
  output logic                 irq_o,
  output logic [VEC_W-1:0]     vector_o,
  output logic                 mode_o
);
  logic [NUM_SRC-1:0] pend_w, set_w;
  logic [LVL_W-1:0]   level_q;
  logic               mode_q;
  logic               found, ack_take, ret_take, mwr_take, priv_set;
  logic [LVL_W:0]     stk_top;
  logic               stk_full, stk_empty;
  logic [CNT_W-1:0]   stk_depth;

  assign ack_take = ack_i && irq_o;
  assign ret_take = ret_i && !ack_take && !stk_empty;
  assign mwr_take = mode_wr_i && !ack_take && !ret_take;
  assign priv_set = mwr_take && (mode_q == MODE_USR);
  assign set_w    = {req_i, trap_i, priv_set, fault_i};

  irqc_pend #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_w),
    .clr_en_i  (ack_take),
    .clr_idx_i (vector_o),
    .pend_o    (pend_w)
  );

  irqc_pick #(.NUM_SRC(NUM_SRC), .NUM_TRAP(TRAP_SRCS)) u_pick (
    .pend_i  (pend_w),
    .level_i (level_q),
    .found_o (found),
    .vec_o   (vector_o)
  );

  irqc_stack #(.DEPTH(STACK_DEPTH), .W(LVL_W + 1)) u_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (ack_take),
    .pop_i   (ret_take),
    .din_i   ({level_q, mode_q}),
    .top_o   (stk_top),
    .full_o  (stk_full),
    .empty_o (stk_empty),
    .depth_o (stk_depth)
  );

  assign irq_o  = found && !stk_full;
  assign mode_o = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= LVL_W'(NUM_SRC);
      mode_q  <= MODE_SUP;
    end else if (ack_take) begin
      level_q <= LVL_W'(vector_o);
      mode_q  <= MODE_SUP;
    end else if (ret_take) begin
      {level_q, mode_q} <= stk_top;
    end else if (mwr_take && mode_q == MODE_SUP) begin
      mode_q <= mode_wdata_i;
    end
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int unsigned NUM_SRC  = 11,
  parameter int unsigned NUM_TRAP = 3,
  parameter int unsigned DEPTH    = 8,
  localparam int unsigned VEC_W   = $clog2(NUM_SRC),
  localparam int unsigned LVL_W   = $clog2(NUM_SRC + 1),
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ack_i,
  input logic               ret_i,
  input logic               mode_wr_i,
  input logic               irq_o,
  input logic [VEC_W-1:0]   vector_o,
  input logic               mode_o,
  input logic [NUM_SRC-1:0] pend_i,
  input logic [LVL_W-1:0]   level_i,
  input logic [CNT_W-1:0]   depth_i
);
  AST_ACK_TO_SUPERVISOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && irq_o |=> !mode_o); // R8

  AST_USER_WRITE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i && mode_o && !ack_i && !ret_i |=> mode_o); // R10

  AST_FULL_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_i == CNT_W'(DEPTH) |-> !irq_o); // R11

  AST_VEC_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> vector_o < VEC_W'(NUM_SRC)); // R2

  AST_VEC_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend_i[vector_o]); // R3

  AST_DEV_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && vector_o >= VEC_W'(NUM_TRAP) |-> LVL_W'(vector_o) < level_i); // R5

  AST_IDLE_ACK_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !irq_o && !ret_i && !mode_wr_i |=> $stable(mode_o) && $stable(depth_i)); // R12
endmodule

bind irqc_top irqc_chk #(
  .NUM_SRC (NUM_SRC),
  .NUM_TRAP(irqc_pkg::TRAP_SRCS),
  .DEPTH   (STACK_DEPTH)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ack_i    (ack_i),
  .ret_i    (ret_i),
  .mode_wr_i(mode_wr_i),
  .irq_o    (irq_o),
  .vector_o (vector_o),
  .mode_o   (mode_o),
  .pend_i   (pend_w),
  .level_i  (level_q),
  .depth_i  (stk_depth)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
  localparam int NL = 8;
  localparam int NS = NL + 3;
  localparam int SD = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] req = '0;
  logic          trap = 0, fault = 0, ack = 0, ret = 0, mwr = 0, mwd = 0;
  logic          irq, mode;
  logic [3:0]    vec;

  int total = 0, bad = 0;
  bit done = 0;
  string tag = "R1";

  // reference model state
  bit m_pend [NS];
  int m_lvl = NS;
  bit m_mode = 0;
  int m_stk [$];

  always #5 clk = ~clk;

  irqc_top #(.NUM_LINES(NL), .STACK_DEPTH(SD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .trap_i(trap), .fault_i(fault),
    .ack_i(ack), .ret_i(ret), .mode_wr_i(mwr), .mode_wdata_i(mwd),
    .irq_o(irq), .vector_o(vec), .mode_o(mode)
  );

  function automatic int pick();
    for (int v = 0; v < NS; v++)
      if (m_pend[v] && (v < 3 || v < m_lvl)) return v;
    return -1;
  endfunction

  function automatic bit exp_irq();
    return pick() >= 0 && m_stk.size() < SD;
  endfunction

  task automatic model_step();
    int  pv   = pick();
    bit  irqe = exp_irq();
    int  clr  = -1;
    bit  pset = 0;
    if (ack && irqe) begin
      m_stk.push_back(m_lvl * 2 + int'(m_mode));
      m_lvl = pv; m_mode = 0; clr = pv;
    end else if (ret && m_stk.size() > 0) begin
      int e = m_stk.pop_back();
      m_lvl = e / 2; m_mode = e[0];
    end else if (mwr) begin
      if (!m_mode) m_mode = mwd;
      else pset = 1;
    end
    for (int v = 0; v < NS; v++) begin
      bit s;
      s = (v == 0) ? fault : (v == 1) ? pset : (v == 2) ? trap : req[v-3];
      m_pend[v] = (m_pend[v] && v != clr) || s;
    end
  endtask

  task automatic compare();
    bit ei = exp_irq();
    total++;
    if (irq !== ei || mode !== m_mode || (ei && vec !== 4'(pick()))) begin
      bad++;
      $display("FAIL %s: irq=%0b mode=%0b vec=%0d exp irq=%0b mode=%0b vec=%0d",
               tag, irq, mode, vec, ei, m_mode, pick());
    end
  endtask

  task automatic cyc(bit a = 0, bit r = 0, bit w = 0, bit wd = 0,
                     bit t = 0, bit f = 0, logic [NL-1:0] rq = '0);
    ack = a; ret = r; mwr = w; mwd = wd; trap = t; fault = f; req = rq;
    @(posedge clk);
    model_step();
    @(negedge clk);
    ack = 0; ret = 0; mwr = 0; mwd = 0; trap = 0; fault = 0; req = '0;
    compare();
  endtask

  initial begin
    for (int v = 0; v < NS; v++) m_pend[v] = 0;
    repeat (3) @(negedge clk);
    tag = "R1"; compare();
    rst_n = 1'b1;
    @(negedge clk); compare();

    // R10 supervisor write to user, then R3 level request held
    tag = "R10"; cyc(.w(1), .wd(1));
    tag = "R3";  cyc(.rq(8'h04));
    repeat (3) cyc();
    tag = "R8";  cyc(.a(1));
    tag = "R9";  cyc(.r(1));

    // R5 masking, R6 preemption, R4 nothing lost
    tag = "R5"; cyc(.rq(8'h10)); cyc(.a(1));
    cyc(.rq(8'h50)); cyc(); cyc(.a(1));
    tag = "R6"; cyc(.rq(8'h02)); cyc(.a(1));
    tag = "R2"; cyc(.rq(8'h81)); cyc();
    tag = "R4"; cyc(.r(1)); cyc(.r(1)); cyc(.a(1)); cyc(.r(1));
    cyc(.a(1)); cyc(.r(1)); cyc(.a(1)); cyc(.r(1)); cyc();

    // R7 traps preempt any level
    tag = "R7"; cyc(.rq(8'h01)); cyc(.a(1));
    cyc(.t(1), .f(1)); cyc(.a(1)); cyc(.a(1)); cyc(.r(1)); cyc(.r(1)); cyc(.r(1));

    // R10 user write ignored, trap raised
    tag = "R10"; cyc(.w(1), .wd(1)); cyc(.w(1), .wd(0)); cyc(); cyc(.a(1)); cyc(.r(1));

    // R11 full stack
    tag = "R11";
    for (int i = 0; i < SD; i++) begin cyc(.t(1)); cyc(.a(1)); end
    cyc(.t(1)); cyc(.a(1)); cyc(.r(1)); cyc(.a(1));
    for (int i = 0; i < SD + 2; i++) cyc(.r(1));

    // R12 and R9 corner cases
    tag = "R12"; cyc(.a(1)); cyc(.a(1), .w(1), .wd(1)); cyc(.w(1), .wd(1));
    cyc(.rq(8'h08)); cyc(.a(1), .r(1)); cyc(.r(1), .w(1), .wd(1)); cyc(.r(1));
    tag = "R9"; cyc(.r(1)); cyc();

    // R2 random mix
    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      cyc(.a($urandom_range(2) == 0), .r($urandom_range(3) == 0),
          .w($urandom_range(7) == 0), .wd(1'($urandom)),
          .t($urandom_range(15) == 0), .f($urandom_range(15) == 0),
          .rq(NL'($urandom & $urandom & $urandom)));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not end, exp finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule